// File: doc/BRIEF.md
# Frame-Paced OUT Endpoint Receive Status

This block is the receive half of an interrupt or bulk OUT endpoint inside a USB device controller. A simplified packet engine hands it data bytes one at a time and then signals the end of a good packet. The bytes are placed in a small receive FIFO. The block keeps a byte count and two status flags, and software reads the packet back through a compact register interface.

Software reads three outcomes from two flags. With both flags clear, nothing arrived. With the packet-done flag set and the FIFO empty, a zero-length packet arrived. With the FIFO non-empty, a short packet is waiting and the count says how many bytes remain to be read.

The endpoint can be serviced from its own interrupt. It can also be paced by start-of-frame events: each frame marker sets a request bit and can raise a separate interrupt. The two interrupts have independent masks. While a packet is held unserviced, the endpoint refuses further traffic by asserting NAK toward the packet engine.

Top module: `frame_rx_endpoint`

## Requirements
- R1: After reset, the status register reads 0, the count reads 0, the mask register reads 2'b11, and `epIrq`, `sofIrq` and `pktNak` are low.
- R2: Each byte accepted from the packet engine increments the count by one. Reads of the data register (address 2) return the bytes in the order they arrived.
- R3: Each read of the data register while the count is non-zero removes one byte and decrements the count. Status bit 0 (FIFO not empty) is 1 exactly when the count is non-zero. A data read with the count at 0 returns 0 and leaves the count at 0.
- R4: `pktEnd` sets status bit 1 (packet done). The packet outcome is encoded in status bits {1,0}: 2'b00 means no packet, 2'b10 means a zero-length packet, and bit 0 = 1 means a short packet whose size is in the count register (address 1).
- R5: While packet done is set, `pktNak` is 1, and incoming bytes and `pktEnd` are ignored: the count and the stored data do not change.
- R6: A `sofPulse` sets status bit 2 (frame request) on the next clock edge.
- R7: Writing status (address 0) with a 1 in bit 1 or bit 2 clears that bit. A 0 in either bit leaves it unchanged. Writes to status bit 0 and to the count register have no effect.
- R8: When a `sofPulse` and a write clearing bit 2 occur in the same cycle, bit 2 ends up set.
- R9: `epIrq` equals packet done AND NOT mask bit 0 (mask register, address 3). A 1 in mask bit 0 masks the endpoint interrupt.
- R10: `sofIrq` equals frame request AND NOT mask bit 1. A 0 in mask bit 1 enables the frame interrupt.
- R11: A byte that arrives while the FIFO holds DEPTH bytes is dropped. The count stays at DEPTH and the first DEPTH bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktByteValid | input | 1 | A received data byte is present |
| pktByte | input | 8 | Received data byte |
| pktEnd | input | 1 | End of a good packet |
| pktNak | output | 1 | Endpoint is busy; the engine must NAK |
| sofPulse | input | 1 | Start-of-frame event, one cycle |
| regRd | input | 1 | Register read strobe (a data read pops the FIFO) |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 status, 1 count, 2 data, 3 mask |
| regWdata | input | 3 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| epIrq | output | 1 | Endpoint interrupt |
| sofIrq | output | 1 | Start-of-frame interrupt |

## Verification
A frame marker and software's write-one-clear of the frame request bit can land on the same clock edge. The bench provokes this by driving `sofPulse` and a status write with bit 2 set in the same cycle. It then reads status and expects the request still set, because setting takes priority over clearing. The packet-length sweep from zero to past the FIFO depth, under both endpoint mask settings, covers the three packet outcomes, overflow dropping and NAK refusal. The expected bytes and counts are computed arithmetically.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } frxStrobes_t;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_MASK = 2'd3;
endpackage

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  frxStrobes_t     strobes,
  input  logic [DW-1:0]   inByte,
  output logic [CNTW-1:0] count,
  output logic [DW-1:0]   headByte,
  output logic            full
);
  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == PTRW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)
        rdPtr <= (rdPtr == PTRW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      unique case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headByte = mem[rdPtr];
  assign full     = (count == CNTW'(DEPTH));

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop && !strobes.push |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/frx_control.sv
module frx_control
  import frx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pktByteValid,
  input  logic            pktEnd,
  input  logic            sofPulse,
  input  logic            regRd,
  input  logic            regWr,
  input  logic [1:0]      regAddr,
  input  logic [2:0]      regWdata,
  input  logic [CNTW-1:0] count,
  input  logic [DW-1:0]   headByte,
  input  logic            full,
  output frxStrobes_t     strobes,
  output logic [7:0]      regRdata,
  output logic            pktNak,
  output logic            epIrq,
  output logic            sofIrq
);
  logic pktDoneQ, sofReqQ, epMaskQ, sofMaskQ;
  logic notEmpty, wrStat, wrMask;

  assign notEmpty = (count != '0);
  assign wrStat   = regWr && (regAddr == ADDR_STAT);
  assign wrMask   = regWr && (regAddr == ADDR_MASK);

  assign strobes.push = pktByteValid && !pktDoneQ && !full;
  assign strobes.pop  = regRd && (regAddr == ADDR_DATA) && notEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktDoneQ <= 1'b0;
      sofReqQ  <= 1'b0;
      epMaskQ  <= 1'b1;
      sofMaskQ <= 1'b1;
    end else begin
      if (pktDoneQ) pktDoneQ <= !(wrStat && regWdata[1]);
      else          pktDoneQ <= pktEnd;
      sofReqQ <= sofPulse || (sofReqQ && !(wrStat && regWdata[2]));
      if (wrMask) begin
        epMaskQ  <= regWdata[0];
        sofMaskQ <= regWdata[1];
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STAT: regRdata = {5'b0, sofReqQ, pktDoneQ, notEmpty};
      ADDR_CNT:  regRdata = 8'(count);
      ADDR_DATA: regRdata = notEmpty ? 8'(headByte) : 8'h00;
      default:   regRdata = {6'b0, sofMaskQ, epMaskQ};
    endcase
  end

  assign pktNak = pktDoneQ;
  assign epIrq  = pktDoneQ && !epMaskQ;
  assign sofIrq = sofReqQ && !sofMaskQ;

  p_sof_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> sofReqQ);

  p_pkt_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd && !pktDoneQ |=> pktDoneQ);

  p_nak_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    pktDoneQ && !strobes.pop |=> count == $past(count));

  p_w1c_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && !regWdata[1] && pktDoneQ |=> pktDoneQ);
endmodule

// File: rtl/frame_rx_endpoint.sv
module frame_rx_endpoint
  import frx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktByteValid,
  input  logic [7:0] pktByte,
  input  logic       pktEnd,
  output logic       pktNak,
  input  logic       sofPulse,
  input  logic       regRd,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic [2:0] regWdata,
  output logic [7:0] regRdata,
  output logic       epIrq,
  output logic       sofIrq
);
  localparam int DW   = 8;
  localparam int CNTW = $clog2(DEPTH + 1);

  frxStrobes_t     strobes;
  logic [CNTW-1:0] count;
  logic [DW-1:0]   headByte;
  logic            full;

  frx_control #(.DEPTH(DEPTH), .DW(DW)) i_control (
    .clk(clk), .rstN(rstN), .pktByteValid(pktByteValid), .pktEnd(pktEnd),
    .sofPulse(sofPulse), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .count(count), .headByte(headByte), .full(full),
    .strobes(strobes), .regRdata(regRdata), .pktNak(pktNak),
    .epIrq(epIrq), .sofIrq(sofIrq)
  );

  frx_datapath #(.DEPTH(DEPTH), .DW(DW)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inByte(pktByte),
    .count(count), .headByte(headByte), .full(full)
  );
endmodule

// File: tb/test_frame_rx_endpoint.sv
module test_frame_rx_endpoint;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pktByteValid, pktEnd, sofPulse, regRd, regWr;
  logic [7:0] pktByte;
  logic [1:0] regAddr;
  logic [2:0] regWdata;
  logic [7:0] regRdata;
  logic       pktNak, epIrq, sofIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  frame_rx_endpoint #(.DEPTH(DEPTH)) i_frame_rx_endpoint (
    .clk(clk), .rstN(rstN), .pktByteValid(pktByteValid), .pktByte(pktByte),
    .pktEnd(pktEnd), .pktNak(pktNak), .sofPulse(sofPulse), .regRd(regRd),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .epIrq(epIrq), .sofIrq(sofIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample combinational outputs, pass one edge.
  task automatic step(input logic bv, input logic [7:0] b, input logic pe,
                      input logic sof, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [2:0] wd,
                      output logic [7:0] rdata);
    @(negedge clk);
    pktByteValid = bv; pktByte = b; pktEnd = pe; sofPulse = sof;
    regRd = rd; regWr = wr; regAddr = a; regWdata = wd;
    #1 rdata = regRdata;
    @(posedge clk);
    #1;
    pktByteValid = 0; pktEnd = 0; sofPulse = 0; regRd = 0; regWr = 0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    step(0, 8'h00, 0, 0, 1, 0, a, 3'b000, d);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [2:0] v);
    logic [7:0] d;
    step(0, 8'h00, 0, 0, 0, 1, a, v, d);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int expCnt;
    pktByteValid = 0; pktByte = 0; pktEnd = 0; sofPulse = 0;
    regRd = 0; regWr = 0; regAddr = 0; regWdata = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rdReg(2'd0, d); check("R1 status", d, 0);
    rdReg(2'd1, d); check("R1 count", d, 0);
    rdReg(2'd3, d); check("R1 mask", d, 3);
    check("R1 epIrq", epIrq, 0);
    check("R1 sofIrq", sofIrq, 0);
    check("R1 nak", pktNak, 0);

    for (int epm = 0; epm < 2; epm++) begin
      for (int n = 0; n <= DEPTH + 2; n++) begin
        wrReg(2'd3, {1'b0, 1'b1, 1'(epm)});
        rdReg(2'd0, d); check("R4 no packet", d[1:0], 0);
        for (int i = 0; i < n; i++)
          step(1, 8'((n * 37 + i * 5) & 255), 0, 0, 0, 0, 2'd0, 3'b000, d);
        step(0, 8'h00, 1, 0, 0, 0, 2'd0, 3'b000, d);
        expCnt = (n < DEPTH) ? n : DEPTH;
        rdReg(2'd1, d); check("R2 R11 count", d, expCnt);
        rdReg(2'd0, d); check("R4 outcome", d[1:0], (expCnt > 0) ? 3 : 2);
        check("R9 epIrq", epIrq, (epm == 0) ? 1 : 0);
        check("R5 nak", pktNak, 1);
        // R5 refused traffic
        step(1, 8'hEE, 0, 0, 0, 0, 2'd0, 3'b000, d);
        step(0, 8'h00, 1, 0, 0, 0, 2'd0, 3'b000, d);
        rdReg(2'd1, d); check("R5 count held", d, expCnt);
        // R7 zero writes and read-only fields
        wrReg(2'd0, 3'b001);
        wrReg(2'd1, 3'b111);
        rdReg(2'd0, d); check("R7 zero write", d[1:0], (expCnt > 0) ? 3 : 2);
        rdReg(2'd1, d); check("R7 count ro", d, expCnt);
        for (int i = 0; i < expCnt; i++) begin
          rdReg(2'd2, d); check("R2 data order", d, (n * 37 + i * 5) & 255);
          rdReg(2'd1, d); check("R3 count dec", d, expCnt - 1 - i);
          rdReg(2'd0, d); check("R3 not empty", d[0], (i < expCnt - 1) ? 1 : 0);
        end
        rdReg(2'd2, d); check("R3 empty read", d, 0);
        rdReg(2'd1, d); check("R3 count stays", d, 0);
        wrReg(2'd0, 3'b010);
        rdReg(2'd0, d); check("R7 w1c done", d[1], 0);
        check("R9 epIrq low", epIrq, 0);
        check("R5 nak low", pktNak, 0);
      end
    end

    for (int sm = 0; sm < 2; sm++) begin
      wrReg(2'd3, {1'b0, 1'(sm), 1'b1});
      step(0, 8'h00, 0, 1, 0, 0, 2'd0, 3'b000, d);
      rdReg(2'd0, d); check("R6 sof req", d[2], 1);
      check("R10 sofIrq", sofIrq, (sm == 0) ? 1 : 0);
      wrReg(2'd0, 3'b011);
      rdReg(2'd0, d); check("R7 sof zero write", d[2], 1);
      wrReg(2'd0, 3'b100);
      rdReg(2'd0, d); check("R7 sof w1c", d[2], 0);
      check("R10 sofIrq low", sofIrq, 0);
      // R8 collision: set and clear in one cycle
      step(0, 8'h00, 0, 1, 0, 1, 2'd0, 3'b100, d);
      rdReg(2'd0, d); check("R8 set wins", d[2], 1);
      wrReg(2'd0, 3'b100);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule